// File: doc/BRIEF.md
# Keyboard Controller Host Command Engine

This block is the host-facing register engine of a PC-style keyboard controller. The host sees two byte ports. The data port is selected with `wr_cmd` = 0 and the command port with `wr_cmd` = 1. A byte written to the command port is decoded at once. Some commands change the mode register, the status register or the output port. Some push a reply byte toward the host. Others arm a second phase that the next data-port write completes. A data-port write that finds nothing armed is handed to the keyboard device as a one-cycle strobe.

The block has four outputs besides its registers. A20 gate follows bit 1 of the output port. A system-reset request goes out as a single-cycle pulse. Reply bytes leave on a push interface that carries a keyboard/aux channel tag. A scan-code translation enable follows bit 6 of the mode register. Every output is registered and changes in the cycle after the write that causes it.

Top module: `kbc_host_engine`

## Requirements
- R1: After reset the status output reads 0x18, the mode register is 0x03, the output port is 0xCF, `a20_o` is 1 and `xlate_o` is 0.
- R2: Command codes 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arm a second phase. The next data-port write performs the armed action and disarms it, so the data write after that one is a plain keyboard write.
- R3: A data-port write with nothing armed raises `kbd_wr_o` for one cycle, with the byte on `dev_byte_o`.
- R4: A command whose upper four bits are 1111 raises `sys_reset_o` for exactly one cycle when its bit 0 is 0. When its bit 0 is 1 it has no effect.
- R5: The data byte after command 0xD1 replaces the output port. `a20_o` takes its bit 1, and its bit 0 being 0 pulses `sys_reset_o` for one cycle.
- R6: Command 0xDF sets output-port bit 1 and drives `a20_o` high. Command 0xDD clears that bit and drives `a20_o` low. No other output-port bit changes.
- R7: Command 0x20 pushes the mode register, 0xD0 pushes the output port and 0xC0 pushes 0x80. All three go on the keyboard channel (`push_aux_o` = 0).
- R8: Command 0xAA sets status bit 2 and pushes 0x55. Commands 0xA9 and 0xAB each push 0x00.
- R9: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4. No other mode bit changes.
- R10: The data byte after command 0x60 replaces the whole mode register, and `xlate_o` equals mode bit 6.
- R11: The data byte after 0xD2 is pushed on the keyboard channel. The data byte after 0xD3 is pushed on the aux channel (`push_aux_o` = 1). The data byte after 0xD4 raises `aux_wr_o` for one cycle, with the byte on `dev_byte_o`.
- R12: Any other command code produces no push, no strobe and no reset pulse. It leaves mode, status and output port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one byte per cycle |
| wr_cmd | input | 1 | 1 selects the command port, 0 the data port |
| wr_byte | input | 8 | Byte written by the host |
| status_o | output | 8 | Status register |
| a20_o | output | 1 | A20 gate, output-port bit 1 |
| sys_reset_o | output | 1 | One-cycle system reset request |
| xlate_o | output | 1 | Scan-code translation enable, mode bit 6 |
| push_valid_o | output | 1 | One-cycle reply byte valid |
| push_aux_o | output | 1 | Reply channel: 0 keyboard, 1 aux |
| push_byte_o | output | 8 | Reply byte |
| kbd_wr_o | output | 1 | One-cycle byte strobe to the keyboard device |
| aux_wr_o | output | 1 | One-cycle byte strobe to the aux device |
| dev_byte_o | output | 8 | Byte carried by the device strobes |

## Verification
The second phase of command 0xD1 does two things in the same cycle. It moves `a20_o` and, when bit 0 of the byte is 0, it fires the reset pulse. To provoke every combination, the bench sweeps all 256 output-port values. After each one it judges the A20 level, whether a reset pulse appeared, and the readback taken through 0xD0. A second overlap is disarming the pending phase while acting on it. A plain data write follows each armed write, and the bench checks that this write reaches the keyboard strobe and not the armed action.

// File: rtl/kbc_host_engine.sv
module kbc_host_engine #(
  parameter logic [7:0] MODE_RST  = 8'h03,
  parameter logic [7:0] STAT_RST  = 8'h18,
  parameter logic [7:0] OPORT_RST = 8'hCF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_cmd,
  input  logic [7:0] wr_byte,
  output logic [7:0] status_o,
  output logic       a20_o,
  output logic       sys_reset_o,
  output logic       xlate_o,
  output logic       push_valid_o,
  output logic       push_aux_o,
  output logic [7:0] push_byte_o,
  output logic       kbd_wr_o,
  output logic       aux_wr_o,
  output logic [7:0] dev_byte_o
);

  logic [7:0] mode_q, stat_q, oport_q, armed_q;

  wire cmd_wr  = wr_en &  wr_cmd;
  wire data_wr = wr_en & ~wr_cmd;

  assign status_o = stat_q;
  assign a20_o    = oport_q[1];
  assign xlate_o  = mode_q[6];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q       <= MODE_RST;
      stat_q       <= STAT_RST;
      oport_q      <= OPORT_RST;
      armed_q      <= 8'h00;
      sys_reset_o  <= 1'b0;
      push_valid_o <= 1'b0;
      push_aux_o   <= 1'b0;
      push_byte_o  <= 8'h00;
      kbd_wr_o     <= 1'b0;
      aux_wr_o     <= 1'b0;
      dev_byte_o   <= 8'h00;
    end else begin
      sys_reset_o  <= 1'b0;
      push_valid_o <= 1'b0;
      kbd_wr_o     <= 1'b0;
      aux_wr_o     <= 1'b0;
      if (cmd_wr) begin
        if (wr_byte[7:4] == 4'hF) begin
          sys_reset_o <= ~wr_byte[0];
        end else begin
          case (wr_byte)
            8'h20: begin push_valid_o <= 1'b1; push_aux_o <= 1'b0; push_byte_o <= mode_q;  end
            8'hD0: begin push_valid_o <= 1'b1; push_aux_o <= 1'b0; push_byte_o <= oport_q; end
            8'hC0: begin push_valid_o <= 1'b1; push_aux_o <= 1'b0; push_byte_o <= 8'h80;   end
            8'hA9, 8'hAB: begin push_valid_o <= 1'b1; push_aux_o <= 1'b0; push_byte_o <= 8'h00; end
            8'hAA: begin
              stat_q[2]    <= 1'b1;
              push_valid_o <= 1'b1;
              push_aux_o   <= 1'b0;
              push_byte_o  <= 8'h55;
            end
            8'h60, 8'hD1, 8'hD2, 8'hD3, 8'hD4: armed_q <= wr_byte;
            8'hA7: mode_q[5]  <= 1'b1;
            8'hA8: mode_q[5]  <= 1'b0;
            8'hAD: mode_q[4]  <= 1'b1;
            8'hAE: mode_q[4]  <= 1'b0;
            8'hDF: oport_q[1] <= 1'b1;
            8'hDD: oport_q[1] <= 1'b0;
            default: ;
          endcase
        end
      end else if (data_wr) begin
        armed_q    <= 8'h00;
        dev_byte_o <= wr_byte;
        case (armed_q)
          8'h00: kbd_wr_o <= 1'b1;
          8'h60: mode_q   <= wr_byte;
          8'hD1: begin oport_q <= wr_byte; sys_reset_o <= ~wr_byte[0]; end
          8'hD2: begin push_valid_o <= 1'b1; push_aux_o <= 1'b0; push_byte_o <= wr_byte; end
          8'hD3: begin push_valid_o <= 1'b1; push_aux_o <= 1'b1; push_byte_o <= wr_byte; end
          8'hD4: aux_wr_o <= 1'b1;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/kbc_host_engine_chk.sv
module kbc_host_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_cmd,
  input logic [7:0] wr_byte,
  input logic       a20_o,
  input logic       sys_reset_o,
  input logic       xlate_o,
  input logic       push_valid_o,
  input logic       kbd_wr_o,
  input logic       aux_wr_o
);

  a_r4_reset_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_o |-> $past(wr_en));

  a_r4_reset_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_reset_o && !wr_en) |=> !sys_reset_o);

  a_r6_a20_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_cmd && wr_byte == 8'hDF) |=> a20_o);

  a_r6_a20_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_cmd && wr_byte == 8'hDD) |=> !a20_o);

  a_r11_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_valid_o, kbd_wr_o, aux_wr_o}));

  a_r3_strobe_from_data: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_wr_o || aux_wr_o) |-> ($past(wr_en) && !$past(wr_cmd)));

  a_r10_xlate_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(xlate_o));

endmodule

bind kbc_host_engine kbc_host_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_byte(wr_byte),
  .a20_o(a20_o), .sys_reset_o(sys_reset_o), .xlate_o(xlate_o),
  .push_valid_o(push_valid_o), .kbd_wr_o(kbd_wr_o), .aux_wr_o(aux_wr_o)
);

// File: tb/kbc_host_engine_tb_top.sv
`timescale 1ns/1ps
module kbc_host_engine_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic wr_cmd = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic [7:0] status_o, push_byte_o, dev_byte_o;
  logic a20_o, sys_reset_o, xlate_o, push_valid_o, push_aux_o, kbd_wr_o, aux_wr_o;

  always #2.5 clk = ~clk;

  kbc_host_engine dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_byte(wr_byte),
    .status_o(status_o), .a20_o(a20_o), .sys_reset_o(sys_reset_o), .xlate_o(xlate_o),
    .push_valid_o(push_valid_o), .push_aux_o(push_aux_o), .push_byte_o(push_byte_o),
    .kbd_wr_o(kbd_wr_o), .aux_wr_o(aux_wr_o), .dev_byte_o(dev_byte_o)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic c_pv, c_paux, c_kw, c_aw, c_rst;
  logic [7:0] c_pb, c_db;
  logic [7:0] e_mode, e_oport, e_stat;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic cmd, input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_cmd = cmd; wr_byte = b;
    @(negedge clk);
    wr_en = 1'b0;
    c_pv = push_valid_o; c_paux = push_aux_o; c_pb = push_byte_o;
    c_kw = kbd_wr_o; c_aw = aux_wr_o; c_db = dev_byte_o; c_rst = sys_reset_o;
  endtask

  task automatic expect_push(input string req, input logic aux, input logic [7:0] b);
    chk(req, {c_pv, c_paux, c_pb}, {1'b1, aux, b});
  endtask

  task automatic expect_quiet(input string req);
    chk(req, {c_pv, c_kw, c_aw, c_rst}, 4'b0000);
  endtask

  function automatic bit known_cmd(input logic [7:0] c);
    if (c[7:4] == 4'hF) return 1;
    case (c)
      8'h20, 8'h60, 8'hA7, 8'hA8, 8'hA9, 8'hAA, 8'hAB, 8'hAD, 8'hAE,
      8'hC0, 8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hD4, 8'hDD, 8'hDF: return 1;
      default: return 0;
    endcase
  endfunction

  initial begin
    #900000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    e_mode = 8'h03; e_oport = 8'hCF; e_stat = 8'h18;

    // R1 reset values
    chk("R1 status", status_o, 32'h18);
    chk("R1 a20", a20_o, 1);
    chk("R1 xlate", xlate_o, 0);
    chk("R1 strobes", {push_valid_o, kbd_wr_o, aux_wr_o, sys_reset_o}, 0);
    wr(1, 8'h20); expect_push("R1 mode", 0, 8'h03);
    wr(1, 8'hD0); expect_push("R1 oport", 0, 8'hCF);

    // R7 constant read
    wr(1, 8'hC0); expect_push("R7 inport", 0, 8'h80);

    // R8 tests
    wr(1, 8'hA9); expect_push("R8 aux test", 0, 8'h00);
    wr(1, 8'hAB); expect_push("R8 kbd test", 0, 8'h00);
    wr(1, 8'hAA); expect_push("R8 self test", 0, 8'h55);
    e_stat = e_stat | 8'h04;
    chk("R8 status bit2", status_o, e_stat);

    // R9 mode bit toggles
    wr(1, 8'hA7); wr(1, 8'h20); expect_push("R9 aux disable", 0, e_mode | 8'h20);
    wr(1, 8'hAD); wr(1, 8'h20); expect_push("R9 kbd disable", 0, e_mode | 8'h30);
    wr(1, 8'hA8); wr(1, 8'h20); expect_push("R9 aux enable", 0, e_mode | 8'h10);
    wr(1, 8'hAE); wr(1, 8'h20); expect_push("R9 kbd enable", 0, e_mode);

    // R10 / R2 full mode sweep
    for (int v = 0; v < 256; v++) begin
      wr(1, 8'h60); expect_quiet("R2 arm 0x60");
      wr(0, 8'(v)); expect_quiet("R10 mode write");
      chk("R10 xlate", xlate_o, (v >> 6) & 1);
      wr(1, 8'h20); expect_push("R10 mode readback", 0, 8'(v));
    end
    e_mode = 8'hFF;
    wr(0, 8'h3C);
    chk("R2 disarmed", {c_kw, c_aw, c_pv, c_db}, {3'b100, 8'h3C});
    wr(1, 8'h20); expect_push("R2 mode kept", 0, e_mode);

    // R11 buffer writes and aux device write
    wr(1, 8'hD2); wr(0, 8'hA5); expect_push("R11 kbd buffer", 0, 8'hA5);
    wr(1, 8'hD3); wr(0, 8'h5A); expect_push("R11 aux buffer", 1, 8'h5A);
    wr(1, 8'hD4); wr(0, 8'hC3);
    chk("R11 aux strobe", {c_aw, c_kw, c_pv, c_db}, {3'b100, 8'hC3});
    wr(0, 8'h77);
    chk("R2 after 0xD4", {c_kw, c_aw, c_db}, {2'b10, 8'h77});

    // R3 plain data writes
    for (int v = 0; v < 256; v += 17) begin
      wr(0, 8'(v));
      chk("R3 kbd strobe", {c_kw, c_aw, c_pv, c_rst, c_db}, {4'b1000, 8'(v)});
    end

    // R5 output port sweep
    for (int v = 0; v < 256; v++) begin
      wr(1, 8'hD1); expect_quiet("R2 arm 0xD1");
      wr(0, 8'(v));
      chk("R5 reset pulse", c_rst, ~v & 1);
      chk("R5 a20", a20_o, (v >> 1) & 1);
      @(negedge clk);
      chk("R5 pulse ends", sys_reset_o, 0);
      wr(1, 8'hD0); expect_push("R5 oport readback", 0, 8'(v));
    end
    e_oport = 8'hFF;

    // R6 A20 commands
    wr(1, 8'hDD);
    chk("R6 a20 low", a20_o, 0);
    wr(1, 8'hD0); expect_push("R6 oport after DD", 0, 8'hFD);
    wr(1, 8'hDF);
    chk("R6 a20 high", a20_o, 1);
    wr(1, 8'hD0); expect_push("R6 oport after DF", 0, 8'hFF);

    // R4 upper nibble F sweep
    for (int v = 240; v < 256; v++) begin
      wr(1, 8'(v));
      chk("R4 pulse", {c_rst, c_pv, c_kw, c_aw}, {~v[0], 3'b000});
      @(negedge clk);
      chk("R4 single cycle", sys_reset_o, 0);
    end

    // R12 unknown command codes
    for (int v = 0; v < 256; v++) begin
      if (!known_cmd(8'(v))) begin
        wr(1, 8'(v)); expect_quiet("R12 no action");
        chk("R12 status", status_o, e_stat);
        wr(1, 8'h20); expect_push("R12 mode", 0, e_mode);
        wr(1, 8'hD0); expect_push("R12 oport", 0, e_oport);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule